// File: doc/BRIEF.md
# Receive Ping-Pong Endpoint Buffer

This block buffers the OUT direction of one device endpoint in two banks, each sized for one maximum-length packet. The serial-side engine deposits an incoming packet into one bank while software drains the other. Software sees a size value that gives the byte count of the bank it currently holds. A trigger strobe hands that bank back and moves software to the other bank. A clear strobe discards everything after a cable reconnect, but only while no packet is being taken in.

The serial-side machine has two states. In `U_IDLE` it waits for a packet start, and `start_accept` moves it to `U_RECV` when the target bank is free. In `U_RECV` it stores bytes, and `end_commit` returns it to `U_IDLE` and flips the write bank. Each bank has three states. `BK_FREE` goes to `BK_FILL` on `fill_begin`. `BK_FILL` goes to `BK_READY` on `fill_end`. `BK_READY` goes back to `BK_FREE` on `hand_back`, and any state goes to `BK_FREE` on `wipe`. The software-side machine has two states. In `RD_WAIT` the current bank has no finished packet. It moves to `RD_OWN` on `pkt_seen` (the current bank became ready) or on `skip_ahead` (a trigger arrives while the other bank is ready). `RD_OWN` returns to `RD_WAIT` on `swap_empty` (trigger, other bank not ready) and stays in `RD_OWN` on `swap_full` (trigger, other bank ready). A clear forces `RD_WAIT`.

Top module: `usb_rx_pingpong`

## Requirements
- R1: After reset `rx_size` is 0, `usb_full` is 0, `cpu_rd_err` is 0, `clr_refused` is 0 and `cpu_rd_data` is 0.
- R2: A packet's bytes are stored in arrival order. Its count is the number of `usb_wr_vld` bytes, capped at MAX_PKT, and bytes beyond the cap are dropped.
- R3: Two rising edges after `usb_end` is sampled, `rx_size` shows the count of the packet if it sits in the bank software holds. It shows 0 while that bank has no finished packet.
- R4: A `cpu_rd` strobe while byte index k is below `rx_size` puts byte k of the bank on `cpu_rd_data` after the next rising edge and advances k. Index k starts at 0 for each bank.
- R5: A `cpu_rd` strobe when k equals `rx_size` (including size 0) raises `cpu_rd_err` for exactly one cycle. It leaves `cpu_rd_data` and k unchanged.
- R6: A `cpu_trig` strobe while software holds a finished packet frees that bank. From the next edge `rx_size` shows the other bank's count.
- R7: A trigger when the other bank holds no finished packet leaves `rx_size` at 0. The next packet that ends then appears normally.
- R8: `usb_full` is 1 exactly when both banks hold finished packets. A `usb_start` while full is ignored, together with any following data and end strobes.
- R9: A `fifo_clr` while no packet is being received frees both banks. After the next edge `rx_size` and `usb_full` are 0, and the next packet goes to bank 0 and is read correctly.
- R10: A `fifo_clr` during packet reception is refused. `clr_refused` is 1 for one cycle after the edge, and the packet in progress completes intact.
- R11: Packets are presented to software in the order they ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usb_start | input | 1 | Start of an incoming packet |
| usb_wr_vld | input | 1 | A data byte is present on `usb_wr_data` |
| usb_wr_data | input | DATA_W | Incoming data byte |
| usb_end | input | 1 | Packet completed and accepted |
| usb_full | output | 1 | Both banks hold finished packets; the next packet must be refused |
| cpu_rd | input | 1 | Software read strobe |
| cpu_rd_data | output | DATA_W | Last byte read |
| cpu_rd_err | output | 1 | Read past the byte count, one-cycle pulse |
| cpu_trig | input | 1 | Release current bank and switch |
| rx_size | output | $clog2(MAX_PKT+1) | Byte count of the bank software holds |
| fifo_clr | input | 1 | Discard all buffered data |
| clr_refused | output | 1 | Clear was refused because a packet was being received |

## Verification
A sweep sends one packet of every length from 0 to MAX_PKT+2 with a length-seeded byte pattern, and reads each packet to its end and one byte past it. This separates off-by-one errors in the count, the cap and the overread guard. Back-to-back packets of different lengths and seeds expose bank-order and size-mux mistakes, and a start attempt while full shows whether a filled bank can be overwritten. Clear strobes are applied once mid-packet and once while idle with both banks full. These tell the refusal path apart from the discard path and check that the bank pointers realign afterward.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;
    typedef enum logic [1:0] {
        BK_FREE  = 2'd0,
        BK_FILL  = 2'd1,
        BK_READY = 2'd2
    } bank_st_e;

    typedef enum logic {
        U_IDLE = 1'b0,
        U_RECV = 1'b1
    } wr_st_e;

    typedef enum logic {
        RD_WAIT = 1'b0,
        RD_OWN  = 1'b1
    } rd_st_e;
endpackage

// File: rtl/usbrx_bank.sv
module usbrx_bank
    import usbrx_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int DATA_W  = 8,
    localparam int CNT_W  = $clog2(MAX_PKT + 1),
    localparam int AW     = $clog2(MAX_PKT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_start,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fill_done,
    input  logic              release_i,
    input  logic              clear_i,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output bank_st_e          st_o,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_PKT);

    logic [DATA_W-1:0] mem [MAX_PKT];
    bank_st_e          st, st_nxt;
    logic [CNT_W-1:0]  cnt;
    logic              room;

    assign room = (cnt < MAX_CNT);

    always_comb begin
        st_nxt = st;
        unique case (st)
            BK_FREE:  if (fill_start) st_nxt = BK_FILL;   // fill_begin
            BK_FILL:  if (fill_done)  st_nxt = BK_READY;  // fill_end
            BK_READY: if (release_i)  st_nxt = BK_FREE;   // hand_back
            default:                  st_nxt = BK_FREE;
        endcase
        if (clear_i) st_nxt = BK_FREE;                    // wipe
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= BK_FREE;
            cnt <= '0;
        end else begin
            st <= st_nxt;
            if (clear_i || fill_start) begin
                cnt <= '0;
            end else if (wr_en && room) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && room && !clear_i && !fill_start) begin
            mem[cnt[AW-1:0]] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
    assign st_o    = st;
    assign cnt_o   = cnt;

    // R2: the stored count never exceeds the bank size
    a_r2_cnt_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= MAX_CNT);

    // R6: software only hands back a bank that holds a finished packet
    a_r6_release_ready: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |-> st == BK_READY);

    // R9: a wipe always leaves the bank free
    a_r9_clear_frees: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> st == BK_FREE);
endmodule

// File: rtl/usbrx_wr_fsm.sv
module usbrx_wr_fsm
    import usbrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       usb_start,
    input  logic       usb_wr_vld,
    input  logic       usb_end,
    input  logic       fifo_clr,
    input  logic [1:0] bank_free,
    output logic [1:0] fill_start,
    output logic [1:0] wr_en,
    output logic [1:0] fill_done,
    output logic       clr_go,
    output logic       clr_refused
);
    wr_st_e state, state_nxt;
    logic   wptr;

    always_comb begin
        state_nxt = state;
        unique case (state)
            U_IDLE: if (!fifo_clr && usb_start && bank_free[wptr]) state_nxt = U_RECV; // start_accept
            U_RECV: if (usb_end) state_nxt = U_IDLE;                                   // end_commit
            default: state_nxt = U_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= U_IDLE;
            wptr        <= 1'b0;
            clr_refused <= 1'b0;
        end else begin
            state       <= state_nxt;
            clr_refused <= fifo_clr && (state == U_RECV);
            if (clr_go) begin
                wptr <= 1'b0;
            end else if (state == U_RECV && usb_end) begin
                wptr <= ~wptr;
            end
        end
    end

    always_comb begin
        fill_start = 2'b00;
        wr_en      = 2'b00;
        fill_done  = 2'b00;
        clr_go     = fifo_clr && (state == U_IDLE);
        if (state == U_IDLE && state_nxt == U_RECV) fill_start[wptr] = 1'b1;
        if (state == U_RECV) begin
            wr_en[wptr]     = usb_wr_vld;
            fill_done[wptr] = usb_end;
        end
    end

    // R8: a start aimed at an occupied bank is not taken
    a_r8_no_start_full: assert property (@(posedge clk) disable iff (!rst_n)
        (state == U_IDLE && usb_start && !bank_free[wptr]) |=> state == U_IDLE);

    // R10: a clear during reception does not end the packet
    a_r10_clr_refused_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (state == U_RECV && fifo_clr && !usb_end) |=> state == U_RECV);
endmodule

// File: rtl/usbrx_rd_fsm.sv
module usbrx_rd_fsm
    import usbrx_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int DATA_W  = 8,
    localparam int CNT_W  = $clog2(MAX_PKT + 1),
    localparam int AW     = $clog2(MAX_PKT)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_rd,
    input  logic                  cpu_trig,
    input  logic                  clr_go,
    input  logic [1:0]            bank_ready,
    input  logic [2*CNT_W-1:0]    cnt_pk,
    input  logic [2*DATA_W-1:0]   rdat_pk,
    output logic [1:0]            release_o,
    output logic [AW-1:0]         rd_addr,
    output logic [CNT_W-1:0]      rx_size,
    output logic [DATA_W-1:0]     cpu_rd_data,
    output logic                  cpu_rd_err
);
    rd_st_e            state, state_nxt;
    logic              rptr, rptr_nxt;
    logic [CNT_W-1:0]  idx;
    logic [CNT_W-1:0]  cur_cnt;
    logic [DATA_W-1:0] cur_dat;

    assign cur_cnt = rptr ? cnt_pk[2*CNT_W-1:CNT_W]    : cnt_pk[CNT_W-1:0];
    assign cur_dat = rptr ? rdat_pk[2*DATA_W-1:DATA_W] : rdat_pk[DATA_W-1:0];

    always_comb begin
        state_nxt = state;
        rptr_nxt  = rptr;
        unique case (state)
            RD_WAIT: begin
                if (bank_ready[rptr]) begin
                    state_nxt = RD_OWN;                       // pkt_seen
                end else if (cpu_trig && bank_ready[~rptr]) begin
                    state_nxt = RD_OWN;                       // skip_ahead
                    rptr_nxt  = ~rptr;
                end
            end
            RD_OWN: begin
                if (cpu_trig) begin
                    rptr_nxt  = ~rptr;
                    state_nxt = bank_ready[~rptr] ? RD_OWN    // swap_full
                                                  : RD_WAIT;  // swap_empty
                end
            end
            default: state_nxt = RD_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= RD_WAIT;
            rptr        <= 1'b0;
            idx         <= '0;
            cpu_rd_data <= '0;
            cpu_rd_err  <= 1'b0;
        end else if (clr_go) begin
            state      <= RD_WAIT;
            rptr       <= 1'b0;
            idx        <= '0;
            cpu_rd_err <= 1'b0;
        end else begin
            state      <= state_nxt;
            rptr       <= rptr_nxt;
            cpu_rd_err <= 1'b0;
            if (state == RD_OWN && cpu_trig) begin
                idx <= '0;
            end else if (cpu_rd) begin
                if (state == RD_OWN && idx < cur_cnt) begin
                    cpu_rd_data <= cur_dat;
                    idx         <= idx + 1'b1;
                end else begin
                    cpu_rd_err <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        release_o       = 2'b00;
        release_o[rptr] = (state == RD_OWN) && cpu_trig && !clr_go;
        rd_addr         = idx[AW-1:0];
        rx_size         = (state == RD_OWN) ? cur_cnt : '0;
    end

    // R5: the read index never passes the owned bank's count
    a_r5_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_OWN) |-> idx <= cur_cnt);

    // R5: an overread returns no new data
    a_r5_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd_err |-> $stable(cpu_rd_data));

    // R3: software only owns a bank that holds a finished packet
    a_r3_own_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_OWN) |-> bank_ready[rptr]);
endmodule

// File: rtl/usb_rx_pingpong.sv
module usb_rx_pingpong
    import usbrx_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int DATA_W  = 8,
    localparam int CNT_W  = $clog2(MAX_PKT + 1),
    localparam int AW     = $clog2(MAX_PKT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usb_start,
    input  logic              usb_wr_vld,
    input  logic [DATA_W-1:0] usb_wr_data,
    input  logic              usb_end,
    output logic              usb_full,
    input  logic              cpu_rd,
    output logic [DATA_W-1:0] cpu_rd_data,
    output logic              cpu_rd_err,
    input  logic              cpu_trig,
    output logic [CNT_W-1:0]  rx_size,
    input  logic              fifo_clr,
    output logic              clr_refused
);
    logic [1:0]          fill_start, wr_en, fill_done, release_b;
    logic [1:0]          bank_free, bank_ready;
    logic                clr_go;
    logic [AW-1:0]       rd_addr;
    logic [2*CNT_W-1:0]  cnt_pk;
    logic [2*DATA_W-1:0] rdat_pk;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        bank_st_e          st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] rdat;

        usbrx_bank #(.MAX_PKT(MAX_PKT), .DATA_W(DATA_W)) i_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .fill_start (fill_start[b]),
            .wr_en      (wr_en[b]),
            .wr_data    (usb_wr_data),
            .fill_done  (fill_done[b]),
            .release_i  (release_b[b]),
            .clear_i    (clr_go),
            .rd_addr    (rd_addr),
            .rd_data    (rdat),
            .st_o       (st),
            .cnt_o      (cnt)
        );

        assign bank_free[b]                      = (st == BK_FREE);
        assign bank_ready[b]                     = (st == BK_READY);
        assign cnt_pk[b*CNT_W +: CNT_W]          = cnt;
        assign rdat_pk[b*DATA_W +: DATA_W]       = rdat;
    end

    usbrx_wr_fsm i_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .usb_start   (usb_start),
        .usb_wr_vld  (usb_wr_vld),
        .usb_end     (usb_end),
        .fifo_clr    (fifo_clr),
        .bank_free   (bank_free),
        .fill_start  (fill_start),
        .wr_en       (wr_en),
        .fill_done   (fill_done),
        .clr_go      (clr_go),
        .clr_refused (clr_refused)
    );

    usbrx_rd_fsm #(.MAX_PKT(MAX_PKT), .DATA_W(DATA_W)) i_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_rd      (cpu_rd),
        .cpu_trig    (cpu_trig),
        .clr_go      (clr_go),
        .bank_ready  (bank_ready),
        .cnt_pk      (cnt_pk),
        .rdat_pk     (rdat_pk),
        .release_o   (release_b),
        .rd_addr     (rd_addr),
        .rx_size     (rx_size),
        .cpu_rd_data (cpu_rd_data),
        .cpu_rd_err  (cpu_rd_err)
    );

    assign usb_full = &bank_ready;

    // R8: only one bank is ever being filled
    a_r8_single_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fill_start | wr_en | fill_done));

    // R8: full drops only through a hand-back or a clear
    a_r8_full_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_full && !cpu_trig && !fifo_clr) |=> usb_full);
endmodule

// File: tb/test_usb_rx_pingpong.sv
`timescale 1ns/1ps
module test_usb_rx_pingpong;
    localparam int MAX_PKT = 8;
    localparam int DATA_W  = 8;
    localparam int CNT_W   = $clog2(MAX_PKT + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              usb_start = 1'b0, usb_wr_vld = 1'b0, usb_end = 1'b0;
    logic [DATA_W-1:0] usb_wr_data = '0;
    logic              usb_full;
    logic              cpu_rd = 1'b0, cpu_trig = 1'b0, fifo_clr = 1'b0;
    logic [DATA_W-1:0] cpu_rd_data;
    logic              cpu_rd_err;
    logic [CNT_W-1:0]  rx_size;
    logic              clr_refused;

    int checks = 0;
    int errors = 0;
    int last_data = 0;

    always #2.5 clk = ~clk;

    usb_rx_pingpong #(.MAX_PKT(MAX_PKT), .DATA_W(DATA_W)) i_usb_rx_pingpong (
        .clk(clk), .rst_n(rst_n), .usb_start(usb_start), .usb_wr_vld(usb_wr_vld),
        .usb_wr_data(usb_wr_data), .usb_end(usb_end), .usb_full(usb_full),
        .cpu_rd(cpu_rd), .cpu_rd_data(cpu_rd_data), .cpu_rd_err(cpu_rd_err),
        .cpu_trig(cpu_trig), .rx_size(rx_size), .fifo_clr(fifo_clr),
        .clr_refused(clr_refused)
    );

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 37) + (i * 11) + 5);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start_pkt();
        @(negedge clk) usb_start = 1'b1;
        @(negedge clk) usb_start = 1'b0;
    endtask

    task automatic put_bytes(input int seed, input int from, input int n);
        for (int i = 0; i < n; i++) begin
            usb_wr_vld  = 1'b1;
            usb_wr_data = pat(seed, from + i);
            @(negedge clk);
        end
        usb_wr_vld = 1'b0;
    endtask

    task automatic end_pkt();
        usb_end = 1'b1;
        @(negedge clk) usb_end = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_pkt(input int seed, input int len);
        start_pkt();
        put_bytes(seed, 0, len);
        end_pkt();
    endtask

    task automatic rd_one();
        cpu_rd = 1'b1;
        @(negedge clk) cpu_rd = 1'b0;
    endtask

    task automatic drain(input string req, input int seed, input int n);
        for (int i = 0; i < n; i++) begin
            rd_one();
            chk(req, cpu_rd_data, pat(seed, i));
            chk(req, cpu_rd_err, 0);
            last_data = pat(seed, i);
        end
    endtask

    task automatic overread();
        rd_one();
        chk("R5 err", cpu_rd_err, 1);
        chk("R5 data held", cpu_rd_data, last_data);
        @(negedge clk);
        chk("R5 err one cycle", cpu_rd_err, 0);
    endtask

    task automatic trig();
        cpu_trig = 1'b1;
        @(negedge clk) cpu_trig = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rx_size", rx_size, 0);
        chk("R1 usb_full", usb_full, 0);
        chk("R1 rd_err", cpu_rd_err, 0);
        chk("R1 clr_refused", clr_refused, 0);
        chk("R1 rd_data", cpu_rd_data, 0);

        // R2 R3 R4 R5 R7: length sweep, including the cap
        for (int len = 0; len <= MAX_PKT + 2; len++) begin
            int exp_n;
            exp_n = (len > MAX_PKT) ? MAX_PKT : len;
            send_pkt(len + 3, len);
            chk("R3 size", rx_size, exp_n);
            chk("R2 not full", usb_full, 0);
            drain("R4 data", len + 3, exp_n);
            overread();
            trig();
            chk("R7 size after empty swap", rx_size, 0);
            overread();
        end

        // R6 R8 R11: two packets queued, third refused
        send_pkt(41, 5);
        send_pkt(42, 8);
        chk("R8 full", usb_full, 1);
        send_pkt(43, 3);
        chk("R8 still full", usb_full, 1);
        chk("R11 first size", rx_size, 5);
        drain("R11 first data", 41, 5);
        trig();
        chk("R6 second size", rx_size, 8);
        chk("R8 full drops", usb_full, 0);
        drain("R11 second data", 42, 8);
        overread();
        trig();
        chk("R7 size zero", rx_size, 0);

        // R10: clear refused mid-packet
        start_pkt();
        put_bytes(50, 0, 3);
        fifo_clr = 1'b1;
        @(negedge clk) fifo_clr = 1'b0;
        chk("R10 refused", clr_refused, 1);
        put_bytes(50, 3, 2);
        chk("R10 refused one cycle", clr_refused, 0);
        end_pkt();
        chk("R10 size", rx_size, 5);
        drain("R10 data", 50, 5);
        trig();

        // R9: clear while idle with both banks full
        send_pkt(60, 4);
        send_pkt(61, 6);
        chk("R9 full before", usb_full, 1);
        fifo_clr = 1'b1;
        @(negedge clk) fifo_clr = 1'b0;
        chk("R9 size", rx_size, 0);
        chk("R9 full", usb_full, 0);
        chk("R9 not refused", clr_refused, 0);
        overread();
        send_pkt(62, 3);
        chk("R9 new size", rx_size, 3);
        drain("R9 new data", 62, 3);
        trig();
        send_pkt(63, 2);
        chk("R9 realign size", rx_size, 2);
        drain("R9 realign data", 63, 2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule